// File: doc/BRIEF.md
# Band-Scaled Visible Watermark Pixel Blender

This block overlays a visible watermark on a grayscale image one pixel pair at a time. Each input beat carries an 8-bit host gray level and the 8-bit watermark gray level for the same position. The block returns the host level brightened by a term proportional to host × watermark. The proportionality factor is not fixed. A comparator sorts the host level into one of five gray bands, and the band picks a strength constant from a small programmable bank. This gives a piecewise-linear stand-in for a perceptual (cube-root) weighting, so darker and brighter regions receive a similar apparent mark.

The constants are unsigned fixed-point values with 16 fractional bits and 4 integer bits. Software derives them from a global strength factor and a per-band curve fit, and loads them through a simple write port while no pixels are moving. The pixel path is a three-stage pipeline with valid/ready handshakes on both sides. It accepts one pixel per clock while the consumer keeps up.

Top module: `vwm_pixel_blend`

## Requirements
- R1: The host level `h` selects a band by the number of edges it exceeds, with edges 2, 64, 128 and 192. Band 0 is `h` ≤ 2, band 1 is 3..64, band 2 is 65..128, band 3 is 129..192, and band 4 is 193..255.
- R2: The output pixel equals `h + floor(K_b × h × w / 65536)`, where `w` is the watermark level and `K_b` is the 20-bit constant of band `b`. A watermark of 0 returns the host unchanged.
- R3: When the sum exceeds 255, the output is 255. The output never wraps and is never below the host level.
- R4: With `out_ready` held high, a pixel accepted at a clock edge appears on `out_valid`/`out_pix` after the third rising edge, counting the accepting edge as the first.
- R5: While `out_valid` is high and `out_ready` is low, `out_pix` and `out_valid` hold and `in_ready` is low. No pixel is lost or duplicated.
- R6: A constant write (`k_we`, band index on `k_sel`, value on `k_val`) takes effect only when `in_valid` is low and no pixel is inside the pipeline. Otherwise the write is dropped and the old constant stays in use.
- R7: After reset `out_valid` is low, `in_ready` is high and every constant is zero, so pixels pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pixel pair present |
| in_ready | output | 1 | Block can take the input pair this cycle |
| in_host | input | 8 | Host gray level |
| in_mark | input | 8 | Watermark gray level |
| out_valid | output | 1 | Watermarked pixel present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_pix | output | 8 | Watermarked gray level |
| k_we | input | 1 | Constant write strobe |
| k_sel | input | 3 | Band index of the constant to write (0..4; other values ignored) |
| k_val | input | 20 | Constant, unsigned with 16 fractional bits |

## Verification
The hardest condition to reach is a constant write that arrives while a pixel is held inside the pipeline by a stalled consumer and no new pixel is offered. Here `in_valid` is already low, so only the in-flight state blocks the write. The bench holds `out_ready` low after sending one pixel and issues the write during the stall. It then drains the pixel and sends the same pixel again to show that the old constant was still used. Band edges are covered with pixel pairs just on each side of every boundary, with constants of different size per band, so a misplaced edge changes the result.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  localparam int unsigned NBANDS = 5;
  localparam int unsigned BAND_W = 3;
  typedef logic [BAND_W-1:0] band_t;
endpackage

// File: rtl/vwm_band_cmp.sv
module vwm_band_cmp
  import vwm_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned NEDGE = NBANDS - 1,
  parameter logic [NEDGE*PIX_W-1:0] EDGES = {8'd192, 8'd128, 8'd64, 8'd2}
) (
  input  logic [PIX_W-1:0] host,
  output band_t            band
);
  logic [NEDGE-1:0] above;

  for (genvar e = 0; e < NEDGE; e++) begin : g_edge
    assign above[e] = host > EDGES[e*PIX_W +: PIX_W];
  end

  always_comb begin
    band = '0;
    for (int e = 0; e < NEDGE; e++) begin
      band = band + band_t'(above[e]);
    end
  end

  // edges ascend, so exceeding a higher edge implies exceeding every lower one
  always_comb begin
    for (int e = 0; e < NEDGE - 1; e++) begin
      p_thermo_r1: assert (!above[e+1] || above[e]);
    end
  end
endmodule

// File: rtl/vwm_coef_bank.sv
module vwm_coef_bank
  import vwm_pkg::*;
#(
  parameter int unsigned COEF_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  band_t             wr_sel,
  input  logic [COEF_W-1:0] wr_val,
  input  band_t             rd_sel,
  output logic [COEF_W-1:0] rd_val
);
  logic [NBANDS-1:0][COEF_W-1:0] coef_q, coef_d;
  logic                          wr_ok;

  assign wr_ok = wr_en && !busy;

  always_comb begin
    coef_d = coef_q;
    for (int b = 0; b < NBANDS; b++) begin
      if (wr_ok && wr_sel == band_t'(b)) coef_d[b] = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_q <= '0;
    else if (wr_ok) coef_q <= coef_d;
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NBANDS; b++) begin
      if (rd_sel == band_t'(b)) rd_val = coef_q[b];
    end
  end

  p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(coef_q));
endmodule

// File: rtl/vwm_blend_pipe.sv
module vwm_blend_pipe #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 20,
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_host,
  input  logic [PIX_W-1:0]  in_mark,
  input  logic [COEF_W-1:0] in_coef,
  output logic              v1,
  output logic              v2,
  output logic              v3,
  output logic [PIX_W-1:0]  pix3
);
  localparam int unsigned P1_W  = COEF_W + PIX_W;
  localparam int unsigned P2_W  = P1_W + PIX_W;
  localparam int unsigned INT_W = P2_W - FRAC_W;
  localparam int unsigned SUM_W = INT_W + 1;
  localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  // stage 1: constant x host
  logic              v1_q;
  logic [PIX_W-1:0]  host1_q, mark1_q;
  logic [P1_W-1:0]   prod1_q, prod1_d;
  // stage 2: (constant x host) x watermark
  logic              v2_q;
  logic [PIX_W-1:0]  host2_q;
  logic [P2_W-1:0]   prod2_q, prod2_d;
  // stage 3: truncate, add, saturate
  logic              v3_q;
  logic [PIX_W-1:0]  host3_q, pix3_q, pix3_d;
  logic [SUM_W-1:0]  sum3;

  always_comb begin
    prod1_d = {{PIX_W{1'b0}}, in_coef} * {{COEF_W{1'b0}}, in_host};
    prod2_d = {{PIX_W{1'b0}}, prod1_q} * {{P1_W{1'b0}}, mark1_q};
    sum3    = SUM_W'(prod2_q >> FRAC_W) + SUM_W'(host2_q);
    pix3_d  = (sum3 > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : sum3[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else if (adv) begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host1_q <= '0;
      mark1_q <= '0;
      prod1_q <= '0;
      host2_q <= '0;
      prod2_q <= '0;
      host3_q <= '0;
      pix3_q  <= '0;
    end else if (adv) begin
      host1_q <= in_host;
      mark1_q <= in_mark;
      prod1_q <= prod1_d;
      host2_q <= host1_q;
      prod2_q <= prod2_d;
      host3_q <= host2_q;
      pix3_q  <= pix3_d;
    end
  end

  assign v1   = v1_q;
  assign v2   = v2_q;
  assign v3   = v3_q;
  assign pix3 = pix3_q;

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v3_q |-> (pix3_q >= host3_q));
endmodule

// File: rtl/vwm_pixel_blend.sv
module vwm_pixel_blend
  import vwm_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 20,
  parameter int unsigned FRAC_W = 16,
  parameter logic [(NBANDS-1)*PIX_W-1:0] EDGES = {8'd192, 8'd128, 8'd64, 8'd2}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_host,
  input  logic [PIX_W-1:0]  in_mark,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix,
  input  logic              k_we,
  input  logic [BAND_W-1:0] k_sel,
  input  logic [COEF_W-1:0] k_val
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  band_t             band;
  logic [COEF_W-1:0] coef;
  logic              adv, busy;
  logic              v1, v2, v3;
  logic [PIX_W-1:0]  pix3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign adv  = !v3 || out_ready;
  assign busy = in_valid || v1 || v2 || v3;

  vwm_band_cmp #(.PIX_W(PIX_W), .NEDGE(NBANDS - 1), .EDGES(EDGES)) u_cmp (
    .host (in_host),
    .band (band)
  );

  vwm_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (k_we),
    .busy   (busy),
    .wr_sel (k_sel),
    .wr_val (k_val),
    .rd_sel (band),
    .rd_val (coef)
  );

  vwm_blend_pipe #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .adv      (adv),
    .in_valid (in_valid),
    .in_host  (in_host),
    .in_mark  (in_mark),
    .in_coef  (coef),
    .v1       (v1),
    .v2       (v2),
    .v3       (v3),
    .pix3     (pix3)
  );

  assign in_ready  = adv && rst_s_n;
  assign out_valid = v3;
  assign out_pix   = pix3;

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  p_stall_ready_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_vwm_pixel_blend.sv
module test_vwm_pixel_blend;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready, k_we;
  logic [7:0]  in_host, in_mark, out_pix;
  logic [2:0]  k_sel;
  logic [19:0] k_val;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #5ns clk = ~clk;

  vwm_pixel_blend i_vwm_pixel_blend (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_host(in_host), .in_mark(in_mark),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .k_we(k_we), .k_sel(k_sel), .k_val(k_val)
  );

  // {host, mark, expected}; band constants 1.0, 1/256, 1/512, 1/1024, 1/2048
  localparam logic [23:0] VEC [14] = '{
    {8'd2,   8'd100, 8'd202},  // R1 top of band 0
    {8'd1,   8'd255, 8'd255},  // R3 saturates
    {8'd0,   8'd255, 8'd0},    // R2
    {8'd3,   8'd255, 8'd5},    // R1 bottom of band 1
    {8'd64,  8'd200, 8'd114},  // R1 top of band 1
    {8'd65,  8'd200, 8'd90},   // R1 bottom of band 2
    {8'd128, 8'd255, 8'd191},  // R1 top of band 2
    {8'd129, 8'd255, 8'd161},  // R1 bottom of band 3
    {8'd192, 8'd100, 8'd210},  // R1 top of band 3
    {8'd193, 8'd100, 8'd202},  // R1 bottom of band 4
    {8'd255, 8'd255, 8'd255},  // R3 saturates
    {8'd240, 8'd0,   8'd240},  // R2 zero watermark
    {8'd250, 8'd40,  8'd254},  // R2
    {8'd200, 8'd255, 8'd224}   // R2
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kwrite(input logic [2:0] sel, input logic [19:0] val);
    @(negedge clk);
    k_we = 1'b1; k_sel = sel; k_val = val;
    @(negedge clk);
    k_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] h, input logic [7:0] w, output int res);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_host = h; in_mark = w;
    @(negedge clk);
    in_valid = 1'b0;
    res = -1;
    for (int i = 0; i < 20; i++) begin
      if (out_valid) begin res = out_pix; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #2ms;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; k_we = 1'b0;
    in_host = '0; in_mark = '0; k_sel = '0; k_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 out_valid after reset", int'(out_valid), 0);
    check("R7 in_ready after reset", int'(in_ready), 1);
    send(8'd77, 8'd255, r);
    check("R7 zero constants pass through", r, 77);

    // R4 latency
    @(negedge clk);
    in_valid = 1'b1; in_host = 8'd50; in_mark = 8'd0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R4 not yet valid after two edges", int'(out_valid), 0);
    @(negedge clk);
    check("R4 valid after third edge", int'(out_valid), 1);
    check("R4 data", int'(out_pix), 50);
    @(negedge clk);

    // load constants while idle
    kwrite(3'd0, 20'h10000);
    kwrite(3'd1, 20'h00100);
    kwrite(3'd2, 20'h00080);
    kwrite(3'd3, 20'h00040);
    kwrite(3'd4, 20'h00020);
    kwrite(3'd6, 20'hFFFFF);   // out of range index, no band affected

    for (int v = 0; v < 14; v++) begin
      send(VEC[v][23:16], VEC[v][15:8], r);
      check($sformatf("R1/R2/R3 vector %0d", v), r, int'(VEC[v][7:0]));
    end

    // R6: write arriving together with a pixel is dropped
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_host = 8'd10; in_mark = 8'd255;
    k_we = 1'b1; k_sel = 3'd1; k_val = 20'h10000;
    @(negedge clk);
    in_valid = 1'b0; k_we = 1'b0;
    repeat (4) @(negedge clk);
    send(8'd10, 8'd255, r);
    check("R6 write with in_valid dropped", r, 19);

    // R5 stall, R6 write with pixel in flight only
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_host = 8'd200; in_mark = 8'd255;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 valid held", int'(out_valid), 1);
    check("R5 data held", int'(out_pix), 224);
    check("R5 in_ready low in stall", int'(in_ready), 0);
    k_we = 1'b1; k_sel = 3'd4; k_val = 20'h00000;
    @(negedge clk);
    k_we = 1'b0;
    check("R5 data still held", int'(out_pix), 224);
    out_ready = 1'b1;
    @(negedge clk);
    check("R5 output taken once", int'(out_valid), 0);
    send(8'd200, 8'd255, r);
    check("R6 write with pixel in flight dropped", r, 224);

    // R6 positive: idle write lands
    kwrite(3'd1, 20'h10000);
    send(8'd10, 8'd20, r);
    check("R6 idle write applied", r, 210);
    kwrite(3'd4, 20'hFFFFF);
    send(8'd255, 8'd255, r);
    check("R3 large constant saturates", r, 255);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule